// File: doc/BRIEF.md
# Unpacked BCD adjust unit

This unit applies one of three corrections to a 16-bit accumulator that holds two unpacked decimal digits, one per byte. It serves an execution pipeline that runs integer adds, multiplies and divides on unpacked BCD operands and then needs a digit fix-up. The pipeline presents an operation code, the accumulator, the incoming auxiliary-carry flag and a radix byte together with a `start` pulse. The unit returns the corrected accumulator and a flag set.

The radix is usually ten, but any byte value is accepted. Two of the operations finish at the clock edge that samples `start`. The first is the fix-up after an addition, which is a conditional nibble correction. The second is the preparation before a division, which is a multiply-accumulate of the high digit into the low byte. The split after a multiplication divides the low byte by the radix. It uses an 8-step restoring divider, holds `busy` while that divider runs, and raises a one-cycle `done` when the result is ready.

A radix of zero on the split raises a divide-error strobe instead of running the divider.

Top module: `bcd_adjust_unit`

## Requirements
- R1: While `rst` is high, and after its release until the first completed operation, `acc_out`, every flag, `busy`, `done` and `div_err` are 0.
- R2: Operation code 0 is the fix-up after addition. When the low nibble of the low byte is above 9, or `aux_in` is 1:
  - the new low byte is ((low + 6) mod 256) with bits 7:4 cleared;
  - the new high byte is (high + 1) mod 256;
  - `flag_c` and `flag_a` are both 1.
- R3: For operation code 0 without that condition, the new low byte is the low byte with bits 7:4 cleared, the high byte is unchanged, and `flag_c` and `flag_a` are 0.
- R4: Operation code 1 is the preparation before division. The new low byte is (low + high × radix) mod 256, the new high byte is 0x00, and `flag_c` and `flag_a` are 0.
- R5: Operation code 2 with a nonzero radix is the split after multiplication. The new high byte is low / radix, the new low byte is low mod radix, and `flag_c` and `flag_a` are 0.
- R6: On every completion that raises no divide error, `flag_s` equals bit 7 of the new low byte. `flag_z` is 1 when that byte is 0. `flag_p` is 1 when that byte has an even number of set bits.
- R7: Operation code 2 with a radix of 0 completes at the sampling edge. At that edge `acc_out` takes the input accumulator unchanged, `div_err` and `done` pulse for one cycle, and the flags keep their previous values.
- R8: Operation codes 0 and 1 raise `done` for one cycle at the edge that samples `start`. Operation code 2 with a nonzero radix raises `busy` at that edge, keeps it high for 8 cycles, and raises `done` for one cycle at the edge where `busy` falls. `busy` and `done` are never high together.
- R9: A `start` seen while `busy` is high has no effect. Operation code 3 has no effect either: no `done`, and `acc_out` and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the operation given by `op` |
| op | input | 2 | 0 fix after add, 1 prepare for divide, 2 split after multiply, 3 no operation |
| acc_in | input | 16 | Accumulator: high digit byte in 15:8, low digit byte in 7:0 |
| aux_in | input | 1 | Incoming auxiliary-carry flag |
| radix | input | 8 | Number base for the divide and multiply operations |
| busy | output | 1 | Divider running; `start` is ignored |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | One-cycle pulse when the split sees a zero radix |
| acc_out | output | 16 | Result accumulator |
| flag_c | output | 1 | Carry flag |
| flag_a | output | 1 | Auxiliary-carry flag |
| flag_s | output | 1 | Sign of the result low byte |
| flag_z | output | 1 | Result low byte is zero |
| flag_p | output | 1 | Result low byte has even parity |

## Verification
A divider that takes one step too few or too many shows at the ports in two ways. The `done` edge moves off the eighth cycle, and the quotient or remainder bytes come out wrong. Both are visible at the completion edge itself.

A broken correction condition or wrap shows in the cycle right after the start pulse, in the high byte and in the carry pair. A stale accept path would let a start that arrives during `busy` corrupt `acc_out`, and that also shows one cycle later. Comparing every output on every cycle against the bench model catches each of these within one cycle of its cause.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

  typedef enum logic [1:0] {
    OP_ADD_FIX   = 2'd0,
    OP_DIV_PREP  = 2'd1,
    OP_MUL_SPLIT = 2'd2,
    OP_NONE      = 2'd3
  } bcd_op_e;

  typedef struct packed {
    logic c;
    logic a;
    logic s;
    logic z;
    logic p;
  } bcd_flags_t;

endpackage

// File: rtl/bcd_add_fix.sv
module bcd_add_fix #(
  parameter int BYTE_W = 8
) (
  input  logic [2*BYTE_W-1:0] acc,
  input  logic                aux,
  output logic [2*BYTE_W-1:0] res,
  output logic                fix
);
  localparam int          NIB_W   = 4;
  localparam logic [NIB_W-1:0]  NIB_MAX = 4'd9;
  localparam logic [BYTE_W-1:0] BUMP    = BYTE_W'(6);

  logic [BYTE_W-1:0] lo, hi, lo_bumped, lo_new, hi_new;

  assign lo        = acc[BYTE_W-1:0];
  assign hi        = acc[2*BYTE_W-1:BYTE_W];
  assign fix       = (lo[NIB_W-1:0] > NIB_MAX) | aux;
  assign lo_bumped = lo + BUMP;

  always_comb begin
    lo_new = '0;
    if (fix) begin
      lo_new[NIB_W-1:0] = lo_bumped[NIB_W-1:0];
      hi_new            = hi + BYTE_W'(1);
    end else begin
      lo_new[NIB_W-1:0] = lo[NIB_W-1:0];
      hi_new            = hi;
    end
  end

  assign res = {hi_new, lo_new};
endmodule

// File: rtl/bcd_div_prep.sv
module bcd_div_prep #(
  parameter int BYTE_W = 8
) (
  input  logic [2*BYTE_W-1:0] acc,
  input  logic [BYTE_W-1:0]   radix,
  output logic [2*BYTE_W-1:0] res
);
  logic [BYTE_W-1:0]   lo, hi;
  logic [2*BYTE_W-1:0] prod;
  logic [BYTE_W-1:0]   mac;

  assign lo   = acc[BYTE_W-1:0];
  assign hi   = acc[2*BYTE_W-1:BYTE_W];
  assign prod = {{BYTE_W{1'b0}}, hi} * {{BYTE_W{1'b0}}, radix};
  assign mac  = lo + prod[BYTE_W-1:0];
  assign res  = {{BYTE_W{1'b0}}, mac};
endmodule

// File: rtl/bcd_restoring_div.sv
module bcd_restoring_div #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] dividend,
  input  logic [BYTE_W-1:0] divisor,
  output logic              busy,
  output logic              last,
  output logic [BYTE_W-1:0] quo_nxt,
  output logic [BYTE_W-1:0] rem_nxt
);
  localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(BYTE_W - 1);

  logic [BYTE_W-1:0] rem_q, quo_q, dvs_q;
  logic [CW-1:0]     step_q;
  logic [BYTE_W:0]   shifted, diff;
  logic              fits;

  assign shifted = {rem_q, quo_q[BYTE_W-1]};
  assign diff    = shifted - {1'b0, dvs_q};
  assign fits    = shifted >= {1'b0, dvs_q};
  assign rem_nxt = fits ? diff[BYTE_W-1:0] : shifted[BYTE_W-1:0];
  assign quo_nxt = {quo_q[BYTE_W-2:0], fits};
  assign last    = busy && (step_q == LAST_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      step_q <= '0;
      busy   <= 1'b0;
    end else if (load && !busy) begin
      rem_q  <= '0;
      quo_q  <= dividend;
      dvs_q  <= divisor;
      step_q <= '0;
      busy   <= 1'b1;
    end else if (busy) begin
      rem_q  <= rem_nxt;
      quo_q  <= quo_nxt;
      step_q <= step_q + CW'(1);
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcd_adj_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          op,
  input  logic [2*BYTE_W-1:0] acc_in,
  input  logic                aux_in,
  input  logic [BYTE_W-1:0]   radix,
  output logic                busy,
  output logic                done,
  output logic                div_err,
  output logic [2*BYTE_W-1:0] acc_out,
  output logic                flag_c,
  output logic                flag_a,
  output logic                flag_s,
  output logic                flag_z,
  output logic                flag_p
);
  localparam int ACC_W = 2 * BYTE_W;

  function automatic bcd_flags_t szp(input logic [BYTE_W-1:0] b, input logic carry);
    bcd_flags_t f;
    f.c = carry;
    f.a = carry;
    f.s = b[BYTE_W-1];
    f.z = (b == '0);
    f.p = ~^b;
    return f;
  endfunction

  bcd_op_e           op_e;
  logic              accept, div_load, radix_zero;
  logic [ACC_W-1:0]  add_res, prep_res;
  logic              add_fix;
  logic              div_busy, div_last;
  logic [BYTE_W-1:0] quo_nxt, rem_nxt;
  bcd_flags_t        flags_q;

  assign op_e       = bcd_op_e'(op);
  assign accept     = start && !div_busy;
  assign radix_zero = (radix == '0);
  assign div_load   = accept && (op_e == OP_MUL_SPLIT) && !radix_zero;

  bcd_add_fix #(.BYTE_W(BYTE_W)) u_add_fix (
    .acc (acc_in),
    .aux (aux_in),
    .res (add_res),
    .fix (add_fix)
  );

  bcd_div_prep #(.BYTE_W(BYTE_W)) u_div_prep (
    .acc   (acc_in),
    .radix (radix),
    .res   (prep_res)
  );

  bcd_restoring_div #(.BYTE_W(BYTE_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .load     (div_load),
    .dividend (acc_in[BYTE_W-1:0]),
    .divisor  (radix),
    .busy     (div_busy),
    .last     (div_last),
    .quo_nxt  (quo_nxt),
    .rem_nxt  (rem_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out <= '0;
      flags_q <= '0;
      done    <= 1'b0;
      div_err <= 1'b0;
    end else begin
      done    <= 1'b0;
      div_err <= 1'b0;
      if (div_last) begin
        acc_out <= {quo_nxt, rem_nxt};
        flags_q <= szp(rem_nxt, 1'b0);
        done    <= 1'b1;
      end else if (accept) begin
        unique case (op_e)
          OP_ADD_FIX: begin
            acc_out <= add_res;
            flags_q <= szp(add_res[BYTE_W-1:0], add_fix);
            done    <= 1'b1;
          end
          OP_DIV_PREP: begin
            acc_out <= prep_res;
            flags_q <= szp(prep_res[BYTE_W-1:0], 1'b0);
            done    <= 1'b1;
          end
          OP_MUL_SPLIT: begin
            if (radix_zero) begin
              acc_out <= acc_in;
              div_err <= 1'b1;
              done    <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign busy   = div_busy;
  assign flag_c = flags_q.c;
  assign flag_a = flags_q.a;
  assign flag_s = flags_q.s;
  assign flag_z = flags_q.z;
  assign flag_p = flags_q.p;
endmodule

// File: rtl/bcd_adjust_chk.sv
module bcd_adjust_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic [1:0]          op,
  input logic [2*BYTE_W-1:0] acc_in,
  input logic                aux_in,
  input logic [BYTE_W-1:0]   radix,
  input logic                busy,
  input logic                done,
  input logic                div_err,
  input logic [2*BYTE_W-1:0] acc_out,
  input logic                flag_c,
  input logic                flag_a,
  input logic                flag_s,
  input logic                flag_z,
  input logic                flag_p
);
  localparam int ITER = BYTE_W;
  localparam int BCW  = $clog2(ITER) + 2;

  logic [BCW-1:0] busy_run;
  logic           go;

  assign go = start && !busy;

  always_ff @(posedge clk) begin
    if (rst)       busy_run <= '0;
    else if (busy) busy_run <= busy_run + BCW'(1);
    else           busy_run <= '0;
  end

  a_r8_busy_excludes_done: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  a_r8_busy_window: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && busy_run == BCW'(ITER)));

  a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
    div_err |-> done);

  a_r7_zero_radix: assert property (@(posedge clk) disable iff (rst)
    (go && op == 2'd2 && radix == '0) |=> (div_err && done && acc_out == $past(acc_in)));

  a_r5_split_goes_busy: assert property (@(posedge clk) disable iff (rst)
    (go && op == 2'd2 && radix != '0) |=> (busy && !done));

  a_r3_upper_nibble_clear: assert property (@(posedge clk) disable iff (rst)
    (go && op == 2'd0) |=> (done && acc_out[7:4] == 4'd0 && flag_c == flag_a));

  a_r2_high_increment: assert property (@(posedge clk) disable iff (rst)
    (go && op == 2'd0 && (acc_in[3:0] > 4'd9 || aux_in)) |=>
      (flag_c && acc_out[2*BYTE_W-1:BYTE_W] == BYTE_W'($past(acc_in[2*BYTE_W-1:BYTE_W]) + 1'b1)));

  a_r4_high_cleared: assert property (@(posedge clk) disable iff (rst)
    (go && op == 2'd1) |=> (done && acc_out[2*BYTE_W-1:BYTE_W] == '0 && !flag_c && !flag_a));

  a_r6_parity: assert property (@(posedge clk) disable iff (rst)
    (done && !div_err) |-> (flag_p == ~^acc_out[BYTE_W-1:0] && flag_s == acc_out[BYTE_W-1]));

  a_r9_null_op: assert property (@(posedge clk) disable iff (rst)
    (go && op == 2'd3) |=> (!done && $stable(acc_out)));
endmodule

bind bcd_adjust_unit bcd_adjust_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op(op), .acc_in(acc_in),
  .aux_in(aux_in), .radix(radix), .busy(busy), .done(done),
  .div_err(div_err), .acc_out(acc_out), .flag_c(flag_c), .flag_a(flag_a),
  .flag_s(flag_s), .flag_z(flag_z), .flag_p(flag_p)
);

// File: tb/sim_bcd_adjust_unit.sv
`timescale 1ns/1ps
module sim_bcd_adjust_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [15:0] acc_in = '0;
  logic        aux_in = 1'b0;
  logic [7:0]  radix = 8'd10;
  logic        busy, done, div_err, flag_c, flag_a, flag_s, flag_z, flag_p;
  logic [15:0] acc_out;

  bcd_adjust_unit u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .acc_in(acc_in),
    .aux_in(aux_in), .radix(radix), .busy(busy), .done(done),
    .div_err(div_err), .acc_out(acc_out), .flag_c(flag_c), .flag_a(flag_a),
    .flag_s(flag_s), .flag_z(flag_z), .flag_p(flag_p)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0, summary_done = 0, started = 0;

  // behavioural reference state
  int    m_acc, m_c, m_a, m_s, m_z, m_p, m_busy, m_done, m_err, m_cnt, m_lo, m_rad;
  string m_tag = "R1";

  task automatic set_flags(input int b, input int carry);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += (b >> i) & 1;
    m_c = carry; m_a = carry;
    m_s = (b >= 128) ? 1 : 0;
    m_z = (b == 0) ? 1 : 0;
    m_p = (ones % 2 == 0) ? 1 : 0;
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_acc = 0; m_c = 0; m_a = 0; m_s = 0; m_z = 0; m_p = 0;
      m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0; m_tag = "R1";
    end else begin
      int lo, hi, nl, nh;
      m_done = 0; m_err = 0;
      lo = int'(acc_in) % 256;
      hi = int'(acc_in) / 256;
      if (m_busy != 0) begin
        if (start) m_tag = "R9";
        m_cnt++;
        if (m_cnt == 8) begin
          nh = m_lo / m_rad; nl = m_lo % m_rad;
          m_acc = nh * 256 + nl;
          set_flags(nl, 0);
          m_busy = 0; m_done = 1; m_tag = "R5";
        end
      end else if (start) begin
        case (op)
          2'd0: begin
            if ((lo % 16) > 9 || aux_in) begin
              nl = ((lo + 6) % 256) % 16; nh = (hi + 1) % 256;
              set_flags(nl, 1); m_tag = "R2";
            end else begin
              nl = lo % 16; nh = hi;
              set_flags(nl, 0); m_tag = "R3";
            end
            m_acc = nh * 256 + nl; m_done = 1;
          end
          2'd1: begin
            nl = (lo + hi * int'(radix)) % 256;
            m_acc = nl; set_flags(nl, 0); m_done = 1; m_tag = "R4";
          end
          2'd2: begin
            if (radix == 0) begin
              m_acc = int'(acc_in); m_err = 1; m_done = 1; m_tag = "R7";
            end else begin
              m_busy = 1; m_cnt = 0; m_lo = lo; m_rad = int'(radix); m_tag = "R8";
            end
          end
          default: m_tag = "R9";
        endcase
      end
    end
  end

  task automatic cmp(input string tag, input int act, input int exp_v);
    n_cmp++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      // accumulator, tagged with the requirement of the last event
      cmp(m_tag, int'(acc_out), m_acc);
      // flag set (R6 rule, carry pair from R2 to R5)
      cmp("R6", int'({flag_c, flag_a, flag_s, flag_z, flag_p}),
          m_c * 16 + m_a * 8 + m_s * 4 + m_z * 2 + m_p);
      // handshake timing (R8) and error strobe (R7)
      cmp("R8", int'({busy, done, div_err}), m_busy * 4 + m_done * 2 + m_err);
    end
  end

  task automatic issue(input int o, input int a, input int x, input int r);
    @(negedge clk);
    start = 1'b1; op = 2'(o); acc_in = 16'(a); aux_in = x[0]; radix = 8'(r);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);                   // R1: reset values compared here
    issue(0, 16'h0009, 0, 10);        // R3 no correction
    issue(0, 16'h050A, 0, 10);        // R2 nibble above nine
    issue(0, 16'h12FF, 0, 10);        // R2 low-byte wrap
    issue(0, 16'hFF03, 1, 10);        // R2 aux forces, high wraps
    issue(0, 16'h07F4, 0, 10);        // R3 upper nibble cleared
    issue(1, 16'h0307, 0, 10);        // R4 37 -> 0x25
    issue(1, 16'hFFFF, 0, 255);       // R4 truncation
    issue(1, 16'h0000, 0, 10);        // R6 zero flag
    issue(2, 16'h0041, 0, 10); settle();   // R5 65 -> 6,5
    issue(2, 16'h00FF, 0, 16); settle();   // R5 radix 16
    issue(2, 16'h0080, 0, 1);  settle();   // R5 radix 1
    issue(2, 16'h0005, 0, 200); settle();  // R5 quotient zero
    issue(2, 16'h1234, 0, 0);              // R7 zero radix
    issue(3, 16'hABCD, 1, 3);              // R9 null operation
    issue(2, 16'h0063, 0, 7);              // R9 starts during busy below
    issue(0, 16'h000F, 1, 10);
    issue(1, 16'h0909, 0, 10);
    settle();
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      start  = ($urandom_range(0, 3) != 0);
      op     = 2'($urandom_range(0, 3));
      acc_in = 16'($urandom);
      aux_in = 1'($urandom_range(0, 1));
      radix  = ($urandom_range(0, 7) == 0) ? 8'd0 : 8'($urandom_range(1, 255));
    end
    @(negedge clk);
    start = 1'b0;
    settle();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end
endmodule